// File: doc/BRIEF.md
# Clock Group Stop Controller

This block gates seven groups of system clocks under three active-low power-management controls: a CPU-stop request, a PCI-stop request and a power-down request. It decides which groups run, passes each group's source clock through a glitch-free gate, and drives an enable for the oscillator and synthesizer core. The controls are asynchronous. They are brought into the free-running reference clock domain through a synchronizer chain, decoded, and registered. Each group's gate then picks up its enable on the falling edge of that group's own clock.

When power-down is requested, every group goes quiet and the oscillator enable drops. When the request is released, the oscillator enable comes back at once. The clock groups stay low until a power-up delay has elapsed, so the synthesizer has time to settle. The delay is a counter whose terminal count is a parameter, derived by default from the reference frequency and a 3 ms target. The CPU-stop and PCI-stop requests stop or restart only their own groups. A fixed number of reference edges separates the control change from the change at the outputs.

Group bit order on `src_clk` and `gated_clk`: bit 0 CPU, bit 1 CPU/2, bit 2 IOAPIC, bit 3 3V66, bit 4 PCI, bit 5 free-running PCI, bit 6 REF/48M.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While `rst_n` is low, all seven `gated_clk` bits are 0 and `osc_en` is 0.
- R2: When `pwr_down_n` is low, all `gated_clk` bits are held at 0 and `osc_en` is 0, whatever `cpu_stop_n` and `pci_stop_n` do.
- R3: With `pwr_down_n` high and `cpu_stop_n` low, bits 0 (CPU) and 3 (3V66) are held at 0. Bits 1, 2, 5 and 6 (CPU/2, IOAPIC, free-running PCI, REF/48M) keep following their source clocks, because these groups ignore `cpu_stop_n`.
- R4: With `pwr_down_n` high and `pci_stop_n` low, bit 4 (PCI) is held at 0. Bit 5 keeps running, and the other groups follow `cpu_stop_n` alone.
- R5: With all three controls high and the power-up delay complete, every `gated_clk` bit follows its source clock.
- R6: With SYNC_STAGES=2, a control is first sampled at reference edge 0. The output keeps its old state during the high phase after edge 2 and shows its new state from the high phase after edge 3. The same latency applies to entering power-down.
- R7: After `pwr_down_n` rises and is first sampled at edge 0, `osc_en` is 0 after edge 1 and 1 after edge 2. The groups stay at 0 through the high phase after edge PWRUP_CYCLES+3 and run from the high phase after edge PWRUP_CYCLES+4.
- R8: Gating is clean. A gated output is 0 throughout every low phase of its source, and within a high phase it is either high for the whole phase or low for the whole phase. A high pulse is never cut short.
- R9: If power-down is requested again during the power-up delay, the delay is abandoned. The next release then waits the full PWRUP_CYCLES again.
- R10: The oscillator enable is high whenever any group is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock. It clocks the synchronizers, the decode and the power-up counter. |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_stop_n | input | 1 | Asynchronous CPU-stop request, active low |
| pci_stop_n | input | 1 | Asynchronous PCI-stop request, active low |
| pwr_down_n | input | 1 | Asynchronous power-down request, active low |
| src_clk | input | 7 | Ungated source clock for each group, in the group bit order above |
| gated_clk | output | 7 | Gated clock for each group |
| osc_en | output | 1 | Enable for the oscillator and synthesizer core |

## Verification
The bench sweeps every stop combination with power-down released. It samples each group in the high phase just before and just after the expected switch edge. A decode that stops CPU/2 or IOAPIC on CPU-stop, or a pipeline one stage short or long, shows up as a mismatch in one of those two phases. The bench also samples late in the same high phase and in the low phase, so a gate that follows the enable combinationally shows a clipped or stray pulse. The power-up test times the release edge to the cycle, and a second release after an aborted wake catches a counter that does not restart and so runs the clocks too early.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  localparam int unsigned NUM_GRP   = 7;
  localparam int unsigned GRP_CPU   = 0;
  localparam int unsigned GRP_DIV2  = 1;
  localparam int unsigned GRP_IOAPIC = 2;
  localparam int unsigned GRP_V66   = 3;
  localparam int unsigned GRP_PCI   = 4;
  localparam int unsigned GRP_PCIF  = 5;
  localparam int unsigned GRP_REF48 = 6;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_WAKE = 2'd1,
    PS_RUN  = 2'd2
  } pwr_state_e;

endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import clkstop_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 42954,
  localparam int unsigned CNT_W = (PWRUP_CYCLES > 2) ? $clog2(PWRUP_CYCLES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_n_s_i,
  output pwr_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             osc_en_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(PWRUP_CYCLES - 1);

  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PS_OFF: begin
        cnt_d = '0;
        if (pd_n_s_i) state_d = PS_WAKE;
      end
      PS_WAKE: begin
        if (!pd_n_s_i) begin
          state_d = PS_OFF;
          cnt_d   = '0;
        end else if (cnt_q == LAST) begin
          state_d = PS_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PS_RUN: begin
        if (!pd_n_s_i) state_d = PS_OFF;
      end
      default: begin
        state_d = PS_OFF;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o  = state_q;
  assign cnt_o    = cnt_q;
  assign osc_en_o = (state_q != PS_OFF);

endmodule

// File: rtl/en_decode.sv
module en_decode
  import clkstop_pkg::*;
(
  input  logic               run_i,
  input  logic               pd_n_i,
  input  logic               cs_n_i,
  input  logic               ps_n_i,
  output logic [NUM_GRP-1:0] en_o
);

  logic live;

  always_comb begin
    live             = run_i & pd_n_i;
    en_o             = '0;
    en_o[GRP_CPU]    = live & cs_n_i;
    en_o[GRP_V66]    = live & cs_n_i;
    en_o[GRP_PCI]    = live & ps_n_i;
    en_o[GRP_DIV2]   = live;
    en_o[GRP_IOAPIC] = live;
    en_o[GRP_PCIF]   = live;
    en_o[GRP_REF48]  = live;
  end

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic clk_o
);

  logic en_lo_q;

  // The enable changes only while the clock is low, so a high phase is never cut.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_lo_q <= 1'b0;
    else         en_lo_q <= en_i;
  end

  assign clk_o = clk_i & en_lo_q;

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clkstop_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned REF_KHZ      = 14318,
  parameter int unsigned PWRUP_US     = 3000,
  parameter int unsigned PWRUP_CYCLES = (REF_KHZ * PWRUP_US) / 1000,
  localparam int unsigned CNT_W = (PWRUP_CYCLES > 2) ? $clog2(PWRUP_CYCLES) : 1
) (
  input  logic               ref_clk,
  input  logic               rst_n,
  input  logic               cpu_stop_n,
  input  logic               pci_stop_n,
  input  logic               pwr_down_n,
  input  logic [NUM_GRP-1:0] src_clk,
  output logic [NUM_GRP-1:0] gated_clk,
  output logic               osc_en
);

  logic [1:0]         rst_pipe_q;
  logic               rst_sync_n;
  logic [2:0]         ctl_s;
  logic               cs_s, ps_s, pd_s;
  pwr_state_e         state_q;
  logic [CNT_W-1:0]   wake_cnt;
  logic [NUM_GRP-1:0] en_d, en_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  ctl_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk_i  (ref_clk),
    .rst_ni (rst_sync_n),
    .d_i    ({pwr_down_n, pci_stop_n, cpu_stop_n}),
    .q_o    (ctl_s)
  );
  assign cs_s = ctl_s[0];
  assign ps_s = ctl_s[1];
  assign pd_s = ctl_s[2];

  pwr_seq #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_seq (
    .clk_i    (ref_clk),
    .rst_ni   (rst_sync_n),
    .pd_n_s_i (pd_s),
    .state_o  (state_q),
    .cnt_o    (wake_cnt),
    .osc_en_o (osc_en)
  );

  en_decode u_dec (
    .run_i  (state_q == PS_RUN),
    .pd_n_i (pd_s),
    .cs_n_i (cs_s),
    .ps_n_i (ps_s),
    .en_o   (en_d)
  );

  always_ff @(posedge ref_clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= '0;
    else             en_q <= en_d;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_gate
    clk_gate_cell u_gate (
      .clk_i  (src_clk[g]),
      .rst_ni (rst_sync_n),
      .en_i   (en_q[g]),
      .clk_o  (gated_clk[g])
    );
  end

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk
  import clkstop_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 2,
  parameter int unsigned CNT_W        = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_GRP-1:0] en_q,
  input logic               osc_en,
  input pwr_state_e         state_q,
  input logic [CNT_W-1:0]   wake_cnt
);

  p_off_no_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en |-> (en_q == '0));

  p_free_groups_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[GRP_CPU] || en_q[GRP_PCI]) |-> (en_q[GRP_PCIF] && en_q[GRP_REF48]
                                          && en_q[GRP_IOAPIC] && en_q[GRP_DIV2]));

  p_run_before_clk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_q[GRP_PCIF]) |-> $past(state_q == PS_RUN));

  p_wake_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PS_WAKE) |-> (32'(wake_cnt) < PWRUP_CYCLES));

  p_osc_covers_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|en_q) |-> osc_en);

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .PWRUP_CYCLES(PWRUP_CYCLES),
  .CNT_W       (CNT_W)
) u_chk (
  .clk_i    (ref_clk),
  .rst_ni   (rst_sync_n),
  .en_q     (en_q),
  .osc_en   (osc_en),
  .state_q  (state_q),
  .wake_cnt (wake_cnt)
);

// File: tb/tb_clk_stop_ctrl.sv
module tb_clk_stop_ctrl;

  localparam int P = 20;

  logic       clk = 1'b0;
  logic       rst_n, cs_n, ps_n, pd_n;
  logic [6:0] gclk;
  logic       osc;
  wire  [6:0] src = {7{clk}};

  int n_tests = 0;
  int n_fail  = 0;

  // group order: 0 CPU,1 CPU/2,2 IOAPIC,3 3V66,4 PCI,5 PCI free,6 REF/48M
  localparam logic [2:0] VEC [8] = '{3'b111, 3'b011, 3'b001, 3'b101,
                                     3'b111, 3'b001, 3'b011, 3'b111};

  always #5 clk = ~clk;

  clk_stop_ctrl #(.PWRUP_CYCLES(P)) dut (
    .ref_clk(clk), .rst_n(rst_n), .cpu_stop_n(cs_n), .pci_stop_n(ps_n),
    .pwr_down_n(pd_n), .src_clk(src), .gated_clk(gclk), .osc_en(osc)
  );

  function automatic logic [6:0] mask(input logic c, input logic p, input logic d);
    return d ? {1'b1, 1'b1, p, c, 1'b1, 1'b1, c} : 7'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic c, input logic p, input logic d);
    @(negedge clk);
    cs_n = c; ps_n = p; pd_n = d;
  endtask

  // Drives a stop/start change and checks R6 latency plus R8 cleanliness.
  task automatic step(input logic c, input logic p, input logic d,
                      input logic [6:0] old_m, input string req);
    set_ctl(c, p, d);
    repeat (3) @(posedge clk);
    #2 check({req, " R6 old"}, {25'b0, gclk}, {25'b0, old_m});
    #2 check("R8 full high", {25'b0, gclk}, {25'b0, old_m});
    @(posedge clk);
    #2 check({req, " R6 new"}, {25'b0, gclk}, {25'b0, mask(c, p, d)});
    #5 check("R8 low phase", {25'b0, gclk}, 32'd0);
  endtask

  // Releases power-down and checks R7 timing.
  task automatic power_up(input string req);
    set_ctl(1'b1, 1'b1, 1'b1);
    @(posedge clk);
    @(posedge clk);
    #2 check({req, " osc edge1"}, {31'b0, osc}, 32'd0);
    @(posedge clk);
    #2 check({req, " osc edge2"}, {31'b0, osc}, 32'd1);
    repeat (P + 1) @(posedge clk);
    #2 check({req, " still held"}, {25'b0, gclk}, 32'd0);
    @(posedge clk);
    #2 check({req, " running"}, {25'b0, gclk}, {25'b0, mask(1'b1, 1'b1, 1'b1)});
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [6:0] cur;
    rst_n = 1'b0; cs_n = 1'b1; ps_n = 1'b1; pd_n = 1'b1;
    repeat (3) @(posedge clk);
    #2 check("R1 gated", {25'b0, gclk}, 32'd0);
    check("R1 osc", {31'b0, osc}, 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (P + 12) @(posedge clk);
    #2 check("R5 all run", {25'b0, gclk}, 32'h7f);

    cur = 7'h7f;
    for (int i = 0; i < 8; i++) begin
      step(VEC[i][2], VEC[i][1], VEC[i][0], cur, "R3 R4 R5 table");
      cur = mask(VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R2: power-down entry from a CPU-stopped state
    set_ctl(1'b0, 1'b1, 1'b0);
    @(posedge clk); @(posedge clk);
    #2 check("R2 osc edge1", {31'b0, osc}, 32'd1);
    @(posedge clk);
    #2 check("R2 osc edge2", {31'b0, osc}, 32'd0);
    check("R6 pd old", {25'b0, gclk}, {25'b0, mask(1'b1, 1'b1, 1'b1)});
    @(posedge clk);
    #2 check("R2 all low", {25'b0, gclk}, 32'd0);

    // R2: stop inputs toggled while powered down have no effect
    set_ctl(1'b1, 1'b0, 1'b0);
    repeat (4) @(posedge clk);
    #2 check("R2 ignore stops", {25'b0, gclk}, 32'd0);
    check("R2 osc off", {31'b0, osc}, 32'd0);
    set_ctl(1'b1, 1'b1, 1'b0);
    repeat (4) @(posedge clk);

    power_up("R7");

    // R9: abort the wake halfway, then a full delay on the next release
    set_ctl(1'b1, 1'b1, 1'b0);
    repeat (6) @(posedge clk);
    set_ctl(1'b1, 1'b1, 1'b1);
    repeat (P / 2) @(posedge clk);
    set_ctl(1'b1, 1'b1, 1'b0);
    repeat (4) @(posedge clk);
    #2 check("R9 abort osc", {31'b0, osc}, 32'd0);
    check("R9 abort held", {25'b0, gclk}, 32'd0);
    power_up("R9");

    step(1'b0, 1'b0, 1'b1, 7'h7f, "R3 R4 both");
    step(1'b1, 1'b1, 1'b1, mask(1'b0, 1'b0, 1'b1), "R5 restart");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule